// File: doc/BRIEF.md
# Retention-Binned DRAM Row Refresh Scheduler

This block is the refresh engine of a memory controller. It walks every row address of one DRAM device and sends a per-row refresh request for each row that is due. Rows are not all refreshed at one rate. Each row belongs to one of three retention classes: weak rows are refreshed every 64 ms, moderate rows every 128 ms, and all other rows every 256 ms. Class membership is held in two bit-array Bloom filters, one for the weakest class and one for the moderate class. A profiling agent fills these filters through an insert port, and a clear input empties them.

Time is cut into 64 ms epochs, counted modulo 4 by a base timer. At the start of each epoch one sweep visits rows in ascending order. Each row address is hashed into both filters. A row that hits in the weak filter is due in every epoch. A row that hits only in the moderate filter is due in epochs 0 and 2. Every other row is due only in epoch 0. A false positive can only make a row refresh more often than it needs to. A row that was inserted always hits, because insertion only sets bits. Due rows are handed to the command arbiter through a request/grant handshake.

Top module: `retention_refresh_sched`

## Requirements
- R1: After reset no request is pending, `epoch_o` is 0 and both filters are empty. The first sweep therefore requests every row with class 00.
- R2: Within one sweep, requests come in strictly ascending row order and each row is requested at most once. One sweep starts per epoch.
- R3: The epoch number advances by one, modulo 4, every EPOCH_CYCLES clock cycles. A sweep starts one cycle after each advance and reports its epoch on `epoch_o`.
- R4: A row inserted into the weak filter (`ins_fast_i`=1) is requested in every epoch with class 10.
- R5: A row whose class is 01 (moderate filter hit, weak filter miss) is requested only in even epochs (0 and 2). A row inserted into the moderate filter (`ins_fast_i`=0) is requested in every even epoch with class 01 or 10.
- R6: A row with class 00 (no filter hit) is requested only in epoch 0, and in epoch 0 every row is requested.
- R7: A row that hits in both filters is reported as class 10. Class 11 never appears.
- R8: While `ref_req_o` is high and `ref_gnt_i` is low, the request stays high and `ref_row_o` and `ref_cls_o` hold their values. A grant completes the request.
- R9: Asserting `clr_i` empties both filters. Afterwards, epochs 1, 2 and 3 issue no request and epoch 0 requests all rows with class 00.
- R10: Inserting further rows never removes an earlier row from its filter. All inserted rows keep their refresh rate however many rows are added (no false negatives, no overflow).
- R11: When `clr_i` and `ins_valid_i` are high in the same cycle, the clear wins and the insert has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Empty both filters |
| ins_valid_i | input | 1 | Insert `ins_row_i` into a filter this cycle |
| ins_fast_i | input | 1 | Filter select for an insert: 1 = weak (64 ms), 0 = moderate (128 ms) |
| ins_row_i | input | ROW_W | Row address to insert |
| ref_req_o | output | 1 | Refresh request to the command arbiter |
| ref_row_o | output | ROW_W | Row address of the pending request |
| ref_cls_o | output | 2 | Class of the pending request: 10 weak, 01 moderate, 00 default |
| ref_gnt_i | input | 1 | Arbiter grant; completes the pending request |
| epoch_o | output | 2 | Epoch number of the current or last sweep |

## Verification
The assertions check the following on every cycle:
- the handshake hold rule;
- that class 00 requests appear only in epoch 0 and class 01 requests only in even epochs;
- that class 11 never appears;
- that the epoch number only steps by one;
- that no request is pending after reset.

Other properties can only be shown by the bench's scenarios, because they depend on what was inserted and on whole sweeps:
- that an inserted row is really requested at its rate;
- that it keeps that rate as the filters fill;
- that a clear really empties the filters and beats a simultaneous insert;
- that every row is visited once per sweep in ascending order;
- that the epoch period is exact.

// File: rtl/retention_refresh_sched.sv
module retention_refresh_sched #(
  parameter int ROW_W        = 16,
  parameter int FAST_BITS    = 2048,
  parameter int FAST_K       = 10,
  parameter int MID_BITS     = 8192,
  parameter int MID_K        = 6,
  parameter int EPOCH_CYCLES = 6400000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             ins_valid_i,
  input  logic             ins_fast_i,
  input  logic [ROW_W-1:0] ins_row_i,
  output logic             ref_req_o,
  output logic [ROW_W-1:0] ref_row_o,
  output logic [1:0]       ref_cls_o,
  input  logic             ref_gnt_i,
  output logic [1:0]       epoch_o
);
  localparam int FAST_IW = $clog2(FAST_BITS);
  localparam int MID_IW  = $clog2(MID_BITS);
  localparam int TMR_W   = $clog2(EPOCH_CYCLES);
  localparam logic [ROW_W-1:0] LAST_ROW = '1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(EPOCH_CYCLES - 1);

  typedef enum logic {S_IDLE, S_SCAN} state_t;

  function automatic logic [31:0] mix(input logic [ROW_W-1:0] row, input int fn);
    logic [31:0] v;
    v = 32'(row);
    return v ^ (v << (fn % 7 + 3)) ^ (v >> (fn % 5 + 1)) ^ (32'h9E3779B9 * 32'(fn + 1));
  endfunction

  function automatic logic [FAST_IW-1:0] fold_fast(input logic [31:0] w);
    logic [FAST_IW-1:0] r;
    r = '0;
    for (int b = 0; b < 32; b++) r[b % FAST_IW] = r[b % FAST_IW] ^ w[b];
    return r;
  endfunction

  function automatic logic [MID_IW-1:0] fold_mid(input logic [31:0] w);
    logic [MID_IW-1:0] r;
    r = '0;
    for (int b = 0; b < 32; b++) r[b % MID_IW] = r[b % MID_IW] ^ w[b];
    return r;
  endfunction

  state_t             st_q;
  logic [ROW_W-1:0]   row_q;
  logic               req_q;
  logic [1:0]         cls_q;
  logic [1:0]         sweep_ep_q;
  logic [1:0]         ep_q;
  logic               pend_q;
  logic [TMR_W-1:0]   timer_q;
  logic [FAST_BITS-1:0] fast_q;
  logic [MID_BITS-1:0]  mid_q;

  logic [FAST_K-1:0]  fast_lk;
  logic [MID_K-1:0]   mid_lk;
  logic [FAST_IW-1:0] fast_ins_ix [FAST_K];
  logic [MID_IW-1:0]  mid_ins_ix  [MID_K];

  genvar gi;
  for (gi = 0; gi < FAST_K; gi++) begin : g_fast
    logic [FAST_IW-1:0] ix_lk;
    assign ix_lk           = fold_fast(mix(row_q, gi));
    assign fast_ins_ix[gi] = fold_fast(mix(ins_row_i, gi));
    assign fast_lk[gi]     = fast_q[ix_lk];
  end

  for (gi = 0; gi < MID_K; gi++) begin : g_mid
    logic [MID_IW-1:0] ix_lk;
    assign ix_lk          = fold_mid(mix(row_q, gi + 16));
    assign mid_ins_ix[gi] = fold_mid(mix(ins_row_i, gi + 16));
    assign mid_lk[gi]     = mid_q[ix_lk];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fast_q <= '0;
    else if (clr_i) fast_q <= '0;
    else if (ins_valid_i && ins_fast_i)
      for (int k = 0; k < FAST_K; k++) fast_q[fast_ins_ix[k]] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mid_q <= '0;
    else if (clr_i) mid_q <= '0;
    else if (ins_valid_i && !ins_fast_i)
      for (int k = 0; k < MID_K; k++) mid_q[mid_ins_ix[k]] <= 1'b1;
  end

  logic fast_hit, mid_hit, ep_even, row_due, step, wrap, start;
  logic [1:0] row_cls;

  assign fast_hit = &fast_lk;
  assign mid_hit  = &mid_lk;
  assign ep_even  = ~sweep_ep_q[0];
  assign row_due  = fast_hit | (mid_hit & ep_even) | (sweep_ep_q == 2'd0);
  assign row_cls  = fast_hit ? 2'b10 : (mid_hit & ep_even) ? 2'b01 : 2'b00;
  assign step     = (st_q == S_SCAN) && (req_q ? ref_gnt_i : !row_due);
  assign wrap     = timer_q == TMR_LAST;
  assign start    = (st_q == S_IDLE) && pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
      ep_q    <= 2'd0;
      pend_q  <= 1'b1;
    end else begin
      timer_q <= wrap ? '0 : timer_q + 1'b1;
      if (wrap) ep_q <= ep_q + 2'd1;
      pend_q <= wrap | (pend_q & ~start);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      row_q      <= '0;
      req_q      <= 1'b0;
      cls_q      <= 2'b00;
      sweep_ep_q <= 2'd0;
    end else begin
      if (start) begin
        st_q       <= S_SCAN;
        row_q      <= '0;
        sweep_ep_q <= ep_q;
      end
      if (st_q == S_SCAN) begin
        if (req_q) begin
          if (ref_gnt_i) req_q <= 1'b0;
        end else if (row_due) begin
          req_q <= 1'b1;
          cls_q <= row_cls;
        end
      end
      if (step) begin
        if (row_q == LAST_ROW) st_q <= S_IDLE;
        else row_q <= row_q + 1'b1;
      end
    end
  end

  assign ref_req_o = req_q;
  assign ref_row_o = row_q;
  assign ref_cls_o = cls_q;
  assign epoch_o   = sweep_ep_q;
endmodule

// File: rtl/retention_refresh_sched_chk.sv
module retention_refresh_sched_chk #(
  parameter int ROW_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_req_o,
  input logic [ROW_W-1:0] ref_row_o,
  input logic [1:0]       ref_cls_o,
  input logic             ref_gnt_i,
  input logic [1:0]       epoch_o
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !ref_req_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req_o && !ref_gnt_i |=> ref_req_o && $stable(ref_row_o) && $stable(ref_cls_o));

  p_default_ep0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req_o && ref_cls_o == 2'b00 |-> epoch_o == 2'd0);

  p_mid_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req_o && ref_cls_o == 2'b01 |-> !epoch_o[0]);

  p_cls_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req_o |-> ref_cls_o != 2'b11);

  p_epoch_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_o != $past(epoch_o) |-> epoch_o == $past(epoch_o) + 2'd1);
endmodule

bind retention_refresh_sched retention_refresh_sched_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_req_o(ref_req_o), .ref_row_o(ref_row_o),
  .ref_cls_o(ref_cls_o), .ref_gnt_i(ref_gnt_i), .epoch_o(epoch_o)
);

// File: tb/retention_refresh_sched_test.sv
module retention_refresh_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 6;
  localparam int ROWS = 1 << ROW_W;
  localparam int EPOCH = 600;

  logic clk = 0, rst_n = 0, clr_i = 0, ins_valid_i = 0, ins_fast_i = 0, ref_gnt_i = 0;
  logic [ROW_W-1:0] ins_row_i = '0;
  logic ref_req_o;
  logic [ROW_W-1:0] ref_row_o;
  logic [1:0] ref_cls_o, epoch_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  retention_refresh_sched #(.ROW_W(ROW_W), .EPOCH_CYCLES(EPOCH)) uut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .ins_valid_i(ins_valid_i),
    .ins_fast_i(ins_fast_i), .ins_row_i(ins_row_i), .ref_req_o(ref_req_o),
    .ref_row_o(ref_row_o), .ref_cls_o(ref_cls_o), .ref_gnt_i(ref_gnt_i), .epoch_o(epoch_o));

  int n_chk = 0, n_bad = 0;
  bit fast_set[ROWS], mid_set[ROWS];
  bit empty_mode = 1;

  bit cur_seen[ROWS], prev_seen[ROWS];
  logic [1:0] cur_cls[ROWS], prev_cls[ROWS];
  int cur_n = 0, prev_n = 0, last_row = -1;
  logic [1:0] last_ep = 0, prev_ep = 0;
  int cyc = 0, last_change = 0, period = 0, sweep_cnt = 0, wait_cnt = 0, pat = 0;
  bit hold = 0;
  logic [ROW_W-1:0] hold_row;
  logic [1:0] hold_cls;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (epoch_o != last_ep) begin
        prev_seen = cur_seen; prev_cls = cur_cls; prev_n = cur_n; prev_ep = last_ep;
        period = cyc - last_change; last_change = cyc;
        for (int r = 0; r < ROWS; r++) cur_seen[r] = 0;
        cur_n = 0; last_row = -1; last_ep = epoch_o; sweep_cnt++;
      end
      if (hold && ref_req_o)
        chk(ref_row_o == hold_row && ref_cls_o == hold_cls, "R8", "held request changed",
            int'(ref_row_o), int'(hold_row));
      if (ref_gnt_i) ref_gnt_i = 0;
      else if (ref_req_o) begin
        if (wait_cnt > 0) wait_cnt--;
        else begin
          if (int'(ref_row_o) <= last_row)
            chk(0, "R2", "row order in sweep", int'(ref_row_o), last_row + 1);
          cur_seen[ref_row_o] = 1; cur_cls[ref_row_o] = ref_cls_o;
          cur_n++; last_row = int'(ref_row_o);
          ref_gnt_i = 1; wait_cnt = pat % 3; pat++;
        end
      end
      hold = ref_req_o && !ref_gnt_i; hold_row = ref_row_o; hold_cls = ref_cls_o;
    end
  end

  task automatic wait_sweep();
    int start = sweep_cnt, t = 0;
    while (sweep_cnt == start && t < 3 * EPOCH) begin @(negedge clk); t++; end
    chk(sweep_cnt != start, "R3", "sweep start watchdog", t, EPOCH);
    chk(int'(epoch_o) == sweep_cnt % 4, "R3", "epoch number", int'(epoch_o), sweep_cnt % 4);
    if (sweep_cnt >= 2) chk(period == EPOCH, "R3", "epoch period", period, EPOCH);
  endtask

  task automatic check_sweep(input string tag);
    int ep = int'(prev_ep), bad = 0;
    if (empty_mode)
      chk(prev_n == (ep == 0 ? ROWS : 0), "R9", {tag, " request count, empty filters"}, prev_n, ep == 0 ? ROWS : 0);
    for (int r = 0; r < ROWS; r++) begin
      if (fast_set[r])
        chk(prev_seen[r] && prev_cls[r] == 2'b10, mid_set[r] ? "R7" : "R4",
            {tag, " weak row class"}, prev_seen[r] ? int'(prev_cls[r]) : -1, 2);
      else if (mid_set[r] && ep % 2 == 0)
        chk(prev_seen[r] && prev_cls[r] != 2'b00, "R5", {tag, " moderate row class"},
            prev_seen[r] ? int'(prev_cls[r]) : -1, 1);
      if (ep == 0 && !prev_seen[r]) bad++;
      if (prev_seen[r] && prev_cls[r] == 2'b00 && ep != 0) bad++;
      if (prev_seen[r] && prev_cls[r] == 2'b01 && ep % 2 != 0) bad++;
      if (prev_seen[r] && prev_cls[r] == 2'b11) bad++;
    end
    chk(bad == 0, "R6", {tag, " class/epoch violations"}, bad, 0);
  endtask

  task automatic do_insert(input int row, input bit fast);
    @(negedge clk);
    ins_valid_i = 1; ins_fast_i = fast; ins_row_i = ROW_W'(row);
    @(negedge clk);
    ins_valid_i = 0;
    if (fast) fast_set[row] = 1; else mid_set[row] = 1;
    empty_mode = 0;
  endtask

  task automatic do_clear(input bit with_ins);
    @(negedge clk);
    clr_i = 1; ins_valid_i = with_ins; ins_fast_i = 1; ins_row_i = ROW_W'(5);
    @(negedge clk);
    clr_i = 0; ins_valid_i = 0;
    for (int r = 0; r < ROWS; r++) begin fast_set[r] = 0; mid_set[r] = 0; end
    empty_mode = 1;
  endtask

  task automatic four_sweeps(input string tag);
    wait_sweep();
    for (int i = 0; i < 4; i++) begin wait_sweep(); check_sweep(tag); end
  endtask

  task automatic t_reset();
    chk(ref_req_o == 0, "R1", "request in reset", int'(ref_req_o), 0);
    chk(epoch_o == 0, "R1", "epoch in reset", int'(epoch_o), 0);
    @(negedge clk); rst_n = 1;
    wait_sweep();
    chk(prev_n == ROWS, "R1", "first sweep request count", prev_n, ROWS);
    check_sweep("R1 first sweep");
  endtask

  task automatic t_bins();
    do_insert(3, 1); do_insert(40, 1);
    do_insert(7, 0); do_insert(63, 0); do_insert(0, 0);
    four_sweeps("R4/R5 bins");
  endtask

  task automatic t_priority();
    do_insert(7, 1); do_insert(20, 0); do_insert(20, 1);
    four_sweeps("R7 both filters");
  endtask

  task automatic t_fill();
    for (int r = 8; r < 30; r++) do_insert(r, 1);
    for (int r = 30; r < 56; r++) do_insert(r, 0);
    four_sweeps("R10 many inserts");
  endtask

  task automatic t_clear();
    do_clear(0);
    four_sweeps("R9 after clear");
  endtask

  task automatic t_clear_ins();
    do_insert(9, 1);
    do_clear(1);
    four_sweeps("R11 clear beats insert");
  endtask

  initial begin
    fork
      begin
        t_reset(); t_bins(); t_priority(); t_fill(); t_clear(); t_clear_ins();
      end
      begin
        repeat (100000) @(negedge clk);
        chk(0, "ALL", "watchdog expired", 100000, 0);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule